// File: doc/BRIEF.md
# Floating-Point Sub-Stage Issue Scheduler

This block decides, one request at a time, whether a floating-point operation may enter a shared arithmetic pipeline in the current cycle. The adder, multiplier and divider of that pipeline are built from eight named sub-stages. The multiplier and the divider finish their work on the adder's mantissa-add and rounding sub-stages, so a plain per-unit busy flag cannot tell whether an issue is safe. The block therefore keeps a table that records, for each future cycle, which sub-stages are already promised to operations in flight.

Each cycle, an incoming request carries an operation class. The block expands that class into a per-cycle sub-stage pattern and compares it row by row against the table. If no sub-stage is claimed twice in any future cycle, the request is granted and its pattern is merged into the table. Otherwise the request is stalled, and the requester holds it and tries again on the next cycle. The table moves one cycle closer to the present on every clock. The block performs no arithmetic.

Top module: `fp_hazard_sched`

## Requirements
- R1: While reset is asserted (`rst_ni` low) and directly after it is released, `resv_o` is all zero. With no request, `grant_o` and `stall_o` are low.
- R2: Class code 0 (add/subtract) uses the sub-stage masks U, S|A, A|R and R|S in four consecutive cycles. The mask bits are U=0, S=1, A=2, R=3, E=4, M=5, N=6, D=7.
- R3: Class code 1 (multiply) uses U, E|M, M, M, M, N, N|A and R in eight consecutive cycles.
- R4: Class code 2 (divide) uses U, A and R, then DIV_D_CYCLES cycles of D, then D|A, D|R, A and R.
- R5: Class codes 3 (negate) and 4 (absolute value) use U and then S. Class code 5 (compare) uses U and then A.
- R6: A request with a legal class raises `grant_o` in the same cycle if no sub-stage of its pattern is already reserved in the same relative cycle. Otherwise it raises `stall_o`. The two outputs are never high together.
- R7: One clock after a grant, row k of `resv_o` (bits [8k+7:8k]) holds the union of the earlier reservations and the granted pattern for the cycle k+1 steps after the grant cycle.
- R8: On every clock, the reservation table moves down by one row and the top row becomes empty, so an operation's mask for step j appears in row j-n, n clocks after its grant.
- R9: A stalled request that is held on the following cycles is granted in the first cycle whose rows no longer overlap its pattern, and is stalled in every cycle before that.
- R10: Class codes 6 and 7 are ignored: `grant_o` and `stall_o` stay low and the table only moves down as in R8.
- R11: While `req_i` is low, `grant_o` and `stall_o` are low whatever `cls_i` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Issue request for this cycle |
| cls_i | input | 3 | Operation class code (0 add, 1 mul, 2 div, 3 neg, 4 abs, 5 cmp) |
| grant_o | output | 1 | Request accepted this cycle |
| stall_o | output | 1 | Request refused this cycle because of a sub-stage clash |
| resv_o | output | 8*(DIV_D_CYCLES+7) | Reservation table, row k = sub-stages claimed k+1 cycles after the current cycle has been registered |

## Verification
`grant_o` and `stall_o` depend combinationally on the request and the registered table, so they are due in the same cycle as the request. The bench drives inputs on the falling edge and samples these outputs one nanosecond later, before the next rising edge. `resv_o` changes only at a rising edge, so the effect of a grant is read at the following falling edge, one edge after the request, and again at each later falling edge to follow the downward movement. Expected grants come from an overlap computed in the bench between the two classes' patterns at each issue distance, for every pair of classes and every distance up to the table depth.

// File: rtl/fp_sched_pkg.sv
package fp_sched_pkg;

    localparam int NSTG = 8;

    typedef logic [NSTG-1:0] stg_mask_t;

    // sub-stage bit positions
    localparam stg_mask_t MK_U = 8'b0000_0001;
    localparam stg_mask_t MK_S = 8'b0000_0010;
    localparam stg_mask_t MK_A = 8'b0000_0100;
    localparam stg_mask_t MK_R = 8'b0000_1000;
    localparam stg_mask_t MK_E = 8'b0001_0000;
    localparam stg_mask_t MK_M = 8'b0010_0000;
    localparam stg_mask_t MK_N = 8'b0100_0000;
    localparam stg_mask_t MK_D = 8'b1000_0000;

    // operation class codes
    localparam logic [2:0] CL_ADD = 3'd0;
    localparam logic [2:0] CL_MUL = 3'd1;
    localparam logic [2:0] CL_DIV = 3'd2;
    localparam logic [2:0] CL_NEG = 3'd3;
    localparam logic [2:0] CL_ABS = 3'd4;
    localparam logic [2:0] CL_CMP = 3'd5;

    // sub-stage mask used by class cls in step k after issue
    function automatic stg_mask_t step_mask(input logic [2:0] cls, input int k, input int dlen);
        stg_mask_t m;
        m = '0;
        case (cls)
            CL_ADD: begin
                case (k)
                    0: m = MK_U;
                    1: m = MK_S | MK_A;
                    2: m = MK_A | MK_R;
                    3: m = MK_R | MK_S;
                    default: m = '0;
                endcase
            end
            CL_MUL: begin
                case (k)
                    0: m = MK_U;
                    1: m = MK_E | MK_M;
                    2, 3, 4: m = MK_M;
                    5: m = MK_N;
                    6: m = MK_N | MK_A;
                    7: m = MK_R;
                    default: m = '0;
                endcase
            end
            CL_DIV: begin
                if (k == 0)                 m = MK_U;
                else if (k == 1)            m = MK_A;
                else if (k == 2)            m = MK_R;
                else if (k < 3 + dlen)      m = MK_D;
                else if (k == 3 + dlen)     m = MK_D | MK_A;
                else if (k == 4 + dlen)     m = MK_D | MK_R;
                else if (k == 5 + dlen)     m = MK_A;
                else if (k == 6 + dlen)     m = MK_R;
                else                        m = '0;
            end
            CL_NEG, CL_ABS: begin
                case (k)
                    0: m = MK_U;
                    1: m = MK_S;
                    default: m = '0;
                endcase
            end
            CL_CMP: begin
                case (k)
                    0: m = MK_U;
                    1: m = MK_A;
                    default: m = '0;
                endcase
            end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/fp_pattern_gen.sv
module fp_pattern_gen
    import fp_sched_pkg::*;
#(
    parameter int DIV_D_CYCLES = 28,
    parameter int WIN          = DIV_D_CYCLES + 7
) (
    input  logic [2:0]                cls_i,
    output logic                      legal_o,
    output logic [WIN-1:0][NSTG-1:0]  rows_o
);

    assign legal_o = (cls_i <= CL_CMP);

    for (genvar k = 0; k < WIN; k++) begin : g_row
        assign rows_o[k] = step_mask(cls_i, k, DIV_D_CYCLES);
    end

endmodule

// File: rtl/fp_overlap_chk.sv
module fp_overlap_chk
    import fp_sched_pkg::*;
#(
    parameter int WIN = 35
) (
    input  logic [WIN-1:0][NSTG-1:0] resv_i,
    input  logic [WIN-1:0][NSTG-1:0] cand_i,
    output logic                     clash_o
);

    logic [WIN-1:0] row_hit;

    for (genvar k = 0; k < WIN; k++) begin : g_cmp
        assign row_hit[k] = |(resv_i[k] & cand_i[k]);
    end

    assign clash_o = |row_hit;

endmodule

// File: rtl/fp_resv_table.sv
module fp_resv_table
    import fp_sched_pkg::*;
#(
    parameter int WIN = 35
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     book_i,
    input  logic [WIN-1:0][NSTG-1:0] book_rows_i,
    output logic [WIN-1:0][NSTG-1:0] rows_o
);

    typedef struct packed {
        logic [WIN-1:0][NSTG-1:0] rows;
    } tbl_s;

    tbl_s tbl_d, tbl_q;
    logic [WIN-1:0][NSTG-1:0] merged;

    always_comb begin
        tbl_d  = tbl_q;
        merged = tbl_q.rows | (book_i ? book_rows_i : '0);
        tbl_d.rows = merged >> NSTG;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tbl_q <= '0;
        else         tbl_q <= tbl_d;
    end

    assign rows_o = tbl_q.rows;

    // a booking must never claim a sub-stage that is already reserved
    assert_no_double_book_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        book_i |-> ((tbl_q.rows & book_rows_i) == '0));

    // with no booking the table only moves down one row
    assert_shift_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !book_i |=> (tbl_q.rows == ($past(tbl_q.rows) >> NSTG)));

    // a booking leaves every earlier reservation in place (moved down one row)
    assert_keep_old_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        book_i |=> ((tbl_q.rows & ($past(tbl_q.rows) >> NSTG)) == ($past(tbl_q.rows) >> NSTG)));

endmodule

// File: rtl/fp_hazard_sched.sv
module fp_hazard_sched
    import fp_sched_pkg::*;
#(
    parameter int DIV_D_CYCLES = 28,
    localparam int WIN         = DIV_D_CYCLES + 7,
    localparam int RW          = WIN * NSTG
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_i,
    input  logic [2:0]    cls_i,
    output logic          grant_o,
    output logic          stall_o,
    output logic [RW-1:0] resv_o
);

    logic                     cls_legal;
    logic                     clash;
    logic [WIN-1:0][NSTG-1:0] cand_rows;
    logic [WIN-1:0][NSTG-1:0] tbl_rows;

    fp_pattern_gen #(
        .DIV_D_CYCLES (DIV_D_CYCLES),
        .WIN          (WIN)
    ) i_pattern (
        .cls_i   (cls_i),
        .legal_o (cls_legal),
        .rows_o  (cand_rows)
    );

    fp_overlap_chk #(
        .WIN (WIN)
    ) i_overlap (
        .resv_i  (tbl_rows),
        .cand_i  (cand_rows),
        .clash_o (clash)
    );

    fp_resv_table #(
        .WIN (WIN)
    ) i_table (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .book_i      (grant_o),
        .book_rows_i (cand_rows),
        .rows_o      (tbl_rows)
    );

    always_comb begin
        grant_o = req_i && cls_legal && !clash;
        stall_o = req_i && cls_legal && clash;
    end

    assign resv_o = tbl_rows;

    // grant and stall exclude each other
    assert_one_answer_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(grant_o && stall_o));

    // every pattern starts on the unpack stage, so a grant needs it free now
    assert_unpack_free_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        grant_o |-> !tbl_rows[0][0]);

    // no answer without a request
    assert_quiet_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |-> (!grant_o && !stall_o));

    // unknown class codes get no answer
    assert_bad_class_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_i && cls_i > 3'd5) |-> (!grant_o && !stall_o));

endmodule

// File: tb/test_fp_hazard_sched.sv
module test_fp_hazard_sched;

    localparam int DL  = 28;
    localparam int WIN = DL + 7;
    localparam int RW  = WIN * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [2:0]    cls = 3'd0;
    logic          grant;
    logic          stall;
    logic [RW-1:0] resv;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    fp_hazard_sched #(.DIV_D_CYCLES(DL)) i_fp_hazard_sched (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .req_i   (req),
        .cls_i   (cls),
        .grant_o (grant),
        .stall_o (stall),
        .resv_o  (resv)
    );

    // bench-side pattern model; bits U0 S1 A2 R3 E4 M5 N6 D7
    function automatic logic [7:0] bpat(input int c, input int k);
        logic [7:0] r;
        r = 8'h00;
        if (k == 0 && c <= 5) r = 8'h01;
        else if (c == 0) begin
            if (k == 1) r = 8'h06; else if (k == 2) r = 8'h0C; else if (k == 3) r = 8'h0A;
        end else if (c == 1) begin
            if (k == 1) r = 8'h30;
            else if (k >= 2 && k <= 4) r = 8'h20;
            else if (k == 5) r = 8'h40;
            else if (k == 6) r = 8'h44;
            else if (k == 7) r = 8'h08;
        end else if (c == 2) begin
            if (k == 1 || k == DL + 5) r = 8'h04;
            else if (k == 2 || k == DL + 6) r = 8'h08;
            else if (k >= 3 && k < DL + 3) r = 8'h80;
            else if (k == DL + 3) r = 8'h84;
            else if (k == DL + 4) r = 8'h88;
        end else if (c == 3 || c == 4) begin
            if (k == 1) r = 8'h02;
        end else if (c == 5) begin
            if (k == 1) r = 8'h04;
        end
        return r;
    endfunction

    function automatic logic bconf(input int a, input int b, input int g);
        for (int k = 0; k < WIN; k++)
            if ((bpat(b, k) & bpat(a, k + g)) != 8'h00) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [RW-1:0] bview(input int a, input int j);
        logic [RW-1:0] v;
        for (int k = 0; k < WIN; k++) v[8*k +: 8] = bpat(a, k + j);
        return v;
    endfunction

    task automatic chk(input logic ok, input string req_tag, input logic [RW-1:0] act, input logic [RW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req_tag, act, exp);
        end
    endtask

    task automatic do_reset();
        req = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // request class a at this negedge and expect a grant, then release
    task automatic issue_first(input int a);
        req = 1'b1;
        cls = 3'(a);
        #1;
        chk(grant === 1'b1 && stall === 1'b0, "R6", RW'(grant), RW'(1));
        @(negedge clk);
        req = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog act=running exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        #1;
        chk(resv === '0, "R1", resv, '0);
        do_reset();
        #1;
        chk(resv === '0 && grant === 1'b0 && stall === 1'b0, "R1", resv, '0);

        // R2 R3 R4 R5 R7 R8: pattern contents and downward movement
        for (int a = 0; a < 6; a++) begin
            do_reset();
            issue_first(a);
            for (int j = 1; j <= WIN; j++) begin
                string tag;
                tag = (a == 0) ? "R2/R7/R8" : (a == 1) ? "R3/R7/R8" :
                      (a == 2) ? "R4/R7/R8" : "R5/R7/R8";
                chk(resv === bview(a, j), tag, resv, bview(a, j));
                @(negedge clk);
            end
        end

        // R6 R11: every pair of classes at every issue distance
        for (int a = 0; a < 6; a++) begin
            for (int b = 0; b < 6; b++) begin
                for (int g = 1; g <= WIN; g++) begin
                    logic e;
                    do_reset();
                    issue_first(a);
                    cls = 3'(b);
                    for (int w = 1; w < g; w++) begin
                        #1;
                        if (w == 1)
                            chk(grant === 1'b0 && stall === 1'b0, "R11", RW'(grant), '0);
                        @(negedge clk);
                    end
                    e = bconf(a, b, g);
                    req = 1'b1;
                    #1;
                    chk(grant === !e && stall === e, "R6", RW'({grant, stall}), RW'({!e, e}));
                    @(negedge clk);
                    req = 1'b0;
                    if (!e) chk(resv === (bview(a, g + 1) | bview(b, 1)), "R7",
                                resv, bview(a, g + 1) | bview(b, 1));
                end
            end
        end

        // R9: held request retried until the first clash-free cycle
        for (int a = 0; a < 6; a++) begin
            for (int b = 0; b < 6; b++) begin
                logic done;
                do_reset();
                issue_first(a);
                req = 1'b1;
                cls = 3'(b);
                done = 1'b0;
                for (int g = 1; g <= WIN + 1 && !done; g++) begin
                    logic e;
                    e = bconf(a, b, g);
                    #1;
                    chk(grant === !e && stall === e, "R9", RW'({grant, stall}), RW'({!e, e}));
                    if (!e) done = 1'b1;
                    @(negedge clk);
                end
                req = 1'b0;
                chk(done, "R9", RW'(done), RW'(1));
            end
        end

        // R10: unknown class codes ignored
        for (int c = 6; c < 8; c++) begin
            do_reset();
            issue_first(1);
            req = 1'b1;
            cls = 3'(c);
            #1;
            chk(grant === 1'b0 && stall === 1'b0, "R10", RW'({grant, stall}), '0);
            @(negedge clk);
            req = 1'b0;
            chk(resv === bview(1, 2), "R10", resv, bview(1, 2));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule